// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the program counter of a single-cycle processor and, on every clock edge, replaces it with the address of the next instruction. Three candidates are formed in parallel each cycle. The sequential one steps the PC by one instruction word. The relative one adds a signed word displacement to the sequential address. The absolute one keeps the top bits of the sequential address and places a word-index field from the instruction below them.

The decode logic supplies three control lines: a branch request, the result of an external equality compare, and a jump request. It also supplies the displacement and target fields taken from the current instruction. The PC has no load enable. It is written at every edge, and a synchronous reset returns it to a fixed start address. Instruction storage, the operand compare and the decoder are outside this block.

Top module: `fetch_addr_gen`

## Requirements
- R1: While `rst` is 1 at a rising edge, `pc_q` becomes `RESET_ADDR` (default 32'h0000_0000) after that edge, whatever the other inputs are.
- R2: With `jmp_en` = 0 and not (`br_en` = 1 and `cmp_eq` = 1), `pc_q` advances by 4 at each edge.
- R3: With `br_en` = 1, `cmp_eq` = 1 and `jmp_en` = 0, the next `pc_q` is `pc_q` + 4 + (`br_off` sign-extended from bit 15, times 4).
- R4: A branch request alone (`br_en` = 1, `cmp_eq` = 0), or an equal flag alone (`cmp_eq` = 1, `br_en` = 0), has no effect: the next `pc_q` is `pc_q` + 4.
- R5: With `jmp_en` = 1, the next `pc_q` is {(`pc_q` + 4)[31:28], `jmp_field`[25:0], 2'b00}.
- R6: When `jmp_en` = 1 and a branch is taken in the same cycle, the jump address wins.
- R7: `pc_q[1:0]` is always 2'b00.
- R8: The upper four bits used by a jump come from `pc_q` + 4 and not from `pc_q`. A jump issued at 32'h0FFF_FFFC therefore lands in the region 4'h1.
- R9: The extreme displacements are exact: `br_off` = 16'h7FFF adds 32'h0001_FFFC and `br_off` = 16'h8000 subtracts 32'h0002_0000, both relative to `pc_q` + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC is written at every rising edge |
| rst | input | 1 | Synchronous active-high reset to `RESET_ADDR` |
| br_off | input | 16 | Signed word displacement of a relative branch |
| jmp_field | input | 26 | Word index of an absolute jump within its region |
| br_en | input | 1 | Instruction is a conditional branch |
| cmp_eq | input | 1 | External operand compare found the operands equal |
| jmp_en | input | 1 | Instruction is an absolute jump |
| pc_q | output | 32 | Current program counter |

## Verification
A taken branch and a jump can be requested in the same cycle. A further overlap pairs reset with a jump. Each overlap is driven with distinct displacement and field values, so that the relative result, the jump result and the reset address all differ. The scoreboard then shows which candidate the PC took. A not-taken branch that is paired with a jump is also driven, and it must give the same jump address. The region-boundary case overlaps the sequential carry into bit 28 with a jump in the same cycle.

// File: rtl/nia_pkg.sv
package nia_pkg;

   // which candidate address is loaded into the PC
   typedef enum logic [1:0] {
      NSEL_SEQ    = 2'd0,
      NSEL_BRANCH = 2'd1,
      NSEL_JUMP   = 2'd2
   } nsel_e;

endpackage

// File: rtl/nia_seq_add.sv
// Sequential successor on word addresses: one instruction further on.
module nia_seq_add #(
   parameter int WORD_W = 30
) (
   input  logic [WORD_W-1:0] pc_word_i,
   output logic [WORD_W-1:0] seq_word_o
);
   localparam logic [WORD_W-1:0] ONE_WORD = WORD_W'(1);

   assign seq_word_o = pc_word_i + ONE_WORD;
endmodule

// File: rtl/nia_branch_tgt.sv
// Relative target: the sequential word address plus a sign-extended displacement.
module nia_branch_tgt #(
   parameter int WORD_W = 30,
   parameter int OFF_W  = 16
) (
   input  logic [WORD_W-1:0] seq_word_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [WORD_W-1:0] tgt_word_o
);
   logic [WORD_W-1:0] disp_word;

   generate
      if (OFF_W < WORD_W) begin : g_extend
         localparam int EXT_W = WORD_W - OFF_W;
         assign disp_word = {{EXT_W{off_i[OFF_W-1]}}, off_i};
      end else begin : g_truncate
         assign disp_word = off_i[WORD_W-1:0];
      end
   endgenerate

   assign tgt_word_o = seq_word_i + disp_word;
endmodule

// File: rtl/nia_jump_tgt.sv
// Absolute target: the region bits of the sequential address above the jump field.
module nia_jump_tgt #(
   parameter int WORD_W = 30,
   parameter int JF_W   = 26
) (
   input  logic [WORD_W-JF_W-1:0] region_i,
   input  logic [JF_W-1:0]        field_i,
   output logic [WORD_W-1:0]      tgt_word_o
);
   assign tgt_word_o = {region_i, field_i};
endmodule

// File: rtl/nia_next_sel.sv
// Picks the next PC word. A jump beats a taken branch, which beats the sequential step.
module nia_next_sel
   import nia_pkg::*;
#(
   parameter int WORD_W = 30
) (
   input  logic              br_en_i,
   input  logic              cmp_eq_i,
   input  logic              jmp_en_i,
   input  logic [WORD_W-1:0] seq_word_i,
   input  logic [WORD_W-1:0] br_word_i,
   input  logic [WORD_W-1:0] jmp_word_i,
   output logic [WORD_W-1:0] next_word_o
);
   nsel_e sel;

   always_comb begin
      if (jmp_en_i)
         sel = NSEL_JUMP;
      else if (br_en_i && cmp_eq_i)
         sel = NSEL_BRANCH;
      else
         sel = NSEL_SEQ;
   end

   always_comb begin
      unique case (sel)
         NSEL_JUMP:   next_word_o = jmp_word_i;
         NSEL_BRANCH: next_word_o = br_word_i;
         default:     next_word_o = seq_word_i;
      endcase
   end
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen #(
   parameter int                 ADDR_W      = 32,
   parameter int                 OFF_W       = 16,
   parameter int                 JF_W        = 26,
   parameter int                 INSTR_BYTES = 4,
   parameter logic [ADDR_W-1:0]  RESET_ADDR  = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OFF_W-1:0]  br_off,
   input  logic [JF_W-1:0]   jmp_field,
   input  logic              br_en,
   input  logic              cmp_eq,
   input  logic              jmp_en,
   output logic [ADDR_W-1:0] pc_q
);
   localparam int ALIGN_BITS  = $clog2(INSTR_BYTES);
   localparam int WORD_W      = ADDR_W - ALIGN_BITS;
   localparam int REGION_BITS = WORD_W - JF_W;
   localparam logic [WORD_W-1:0] RESET_WORD = RESET_ADDR[ADDR_W-1:ALIGN_BITS];

   // elaboration-time parameter checks
   generate
      if (INSTR_BYTES < 2 || (1 << ALIGN_BITS) != INSTR_BYTES) begin : g_bad_step
         $error("INSTR_BYTES must be a power of two of at least 2");
      end
      if (REGION_BITS < 1) begin : g_bad_region
         $error("jump field leaves no region bits");
      end
      if (OFF_W < 2 || OFF_W > WORD_W) begin : g_bad_off
         $error("OFF_W out of range");
      end
      if (RESET_ADDR[ALIGN_BITS-1:0] != '0) begin : g_bad_reset
         $error("RESET_ADDR must be instruction aligned");
      end
   endgenerate

   logic [WORD_W-1:0] pc_word;
   logic [WORD_W-1:0] seq_word;
   logic [WORD_W-1:0] br_word;
   logic [WORD_W-1:0] jmp_word;
   logic [WORD_W-1:0] next_word;

   nia_seq_add #(.WORD_W(WORD_W)) u_seq (
      .pc_word_i  (pc_word),
      .seq_word_o (seq_word)
   );

   nia_branch_tgt #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_br (
      .seq_word_i (seq_word),
      .off_i      (br_off),
      .tgt_word_o (br_word)
   );

   nia_jump_tgt #(.WORD_W(WORD_W), .JF_W(JF_W)) u_jmp (
      .region_i   (seq_word[WORD_W-1 -: REGION_BITS]),
      .field_i    (jmp_field),
      .tgt_word_o (jmp_word)
   );

   nia_next_sel #(.WORD_W(WORD_W)) u_sel (
      .br_en_i     (br_en),
      .cmp_eq_i    (cmp_eq),
      .jmp_en_i    (jmp_en),
      .seq_word_i  (seq_word),
      .br_word_i   (br_word),
      .jmp_word_i  (jmp_word),
      .next_word_o (next_word)
   );

   // loaded every cycle, no enable
   always_ff @(posedge clk) begin
      if (rst)
         pc_word <= RESET_WORD;
      else
         pc_word <= next_word;
   end

   assign pc_q = {pc_word, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/fetch_addr_gen_chk.sv
// The checker works on byte addresses, apart from the word-level datapath it watches.
module fetch_addr_gen_chk #(
   parameter int                ADDR_W      = 32,
   parameter int                OFF_W       = 16,
   parameter int                JF_W        = 26,
   parameter int                INSTR_BYTES = 4,
   parameter logic [ADDR_W-1:0] RESET_ADDR  = '0
) (
   input logic              clk,
   input logic              rst,
   input logic [OFF_W-1:0]  br_off,
   input logic [JF_W-1:0]   jmp_field,
   input logic              br_en,
   input logic              cmp_eq,
   input logic              jmp_en,
   input logic [ADDR_W-1:0] pc_q
);
   localparam int AL = $clog2(INSTR_BYTES);
   localparam int RB = ADDR_W - JF_W - AL;
   localparam int XW = ADDR_W - OFF_W - AL;

   logic [ADDR_W-1:0] seq_b, disp_b, jump_b, rel_b;
   assign seq_b  = pc_q + ADDR_W'(INSTR_BYTES);
   assign disp_b = {{XW{br_off[OFF_W-1]}}, br_off, {AL{1'b0}}};
   assign rel_b  = seq_b + disp_b;
   assign jump_b = {seq_b[ADDR_W-1 -: RB], jmp_field, {AL{1'b0}}};

   p_reset_load_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> pc_q == RESET_ADDR);

   p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
      (!jmp_en && !(br_en && cmp_eq)) |=> pc_q == $past(seq_b));

   p_branch_taken_r3: assert property (@(posedge clk) disable iff (rst)
      (br_en && cmp_eq && !jmp_en) |=> pc_q == $past(rel_b));

   p_branch_ignored_r4: assert property (@(posedge clk) disable iff (rst)
      ((br_en != cmp_eq) && !jmp_en) |=> pc_q == $past(seq_b));

   p_jump_target_r5: assert property (@(posedge clk) disable iff (rst)
      jmp_en |=> pc_q == $past(jump_b));

   p_jump_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (jmp_en && br_en && cmp_eq) |=> pc_q != $past(rel_b) || $past(rel_b) == $past(jump_b));

   p_aligned_r7: assert property (@(posedge clk) disable iff (rst)
      pc_q[AL-1:0] == '0);
endmodule

bind fetch_addr_gen fetch_addr_gen_chk #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .JF_W(JF_W),
   .INSTR_BYTES(INSTR_BYTES), .RESET_ADDR(RESET_ADDR)
) u_chk (
   .clk(clk), .rst(rst), .br_off(br_off), .jmp_field(jmp_field),
   .br_en(br_en), .cmp_eq(cmp_eq), .jmp_en(jmp_en), .pc_q(pc_q)
);

// File: tb/test_fetch_addr_gen.sv
module test_fetch_addr_gen;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] br_off = '0;
   logic [25:0] jmp_field = '0;
   logic        br_en = 1'b0;
   logic        cmp_eq = 1'b0;
   logic        jmp_en = 1'b0;
   logic [31:0] pc_q;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] model = '0;

   always #5 clk = ~clk;   // 100 MHz

   fetch_addr_gen i_fetch_addr_gen (
      .clk(clk), .rst(rst), .br_off(br_off), .jmp_field(jmp_field),
      .br_en(br_en), .cmp_eq(cmp_eq), .jmp_en(jmp_en), .pc_q(pc_q)
   );

   // driver: apply one cycle of inputs at the falling edge and queue the expected PC
   task automatic drive(input bit r, input bit b, input bit e, input bit j,
                        input logic [15:0] im, input logic [25:0] f, input string tag);
      logic [31:0] seq;
      rst = r; br_en = b; cmp_eq = e; jmp_en = j; br_off = im; jmp_field = f;
      seq = model + 32'd4;
      if (r)           model = 32'h0000_0000;
      else if (j)      model = {seq[31:28], f, 2'b00};
      else if (b && e) model = seq + {{14{im[15]}}, im, 2'b00};
      else             model = seq;
      exp_q.push_back(model);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   // monitor: compare after each rising edge, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pc_q !== e) begin
               errors++;
               $display("FAIL %s pc=%h expected=%h", t, pc_q, e);
            end
            checks++;
            if (pc_q[1:0] !== 2'b00) begin
               errors++;
               $display("FAIL R7 low bits=%b expected=00", pc_q[1:0]);
            end
         end
      end
   end

   initial begin
      @(negedge clk);
      drive(1, 0, 0, 1, 16'h0000, 26'h0000123, "R1 reset while jump asserted");
      drive(0, 0, 0, 0, 16'h0000, 26'h0, "R2 step 1");
      drive(0, 0, 0, 0, 16'h1234, 26'h0, "R2 step 2");
      drive(0, 0, 0, 0, 16'hFFFF, 26'h0, "R2 step 3");
      drive(0, 1, 0, 0, 16'h0040, 26'h0, "R4 branch without equal");
      drive(0, 0, 1, 0, 16'h0040, 26'h0, "R4 equal without branch");
      drive(0, 1, 1, 0, 16'h0003, 26'h0, "R3 forward branch");
      drive(0, 1, 1, 0, 16'hFFFE, 26'h0, "R3 backward branch");
      drive(0, 0, 0, 1, 16'h0000, 26'h3FF_FFFF, "R5 jump to region top");
      drive(0, 0, 0, 0, 16'h0000, 26'h0, "R8 sequential carry into bit 28");
      drive(0, 0, 0, 1, 16'h0000, 26'h0000010, "R5 jump with nonzero region");
      drive(1, 0, 0, 0, 16'h0000, 26'h0, "R1 mid-run reset");
      drive(0, 0, 0, 1, 16'h0000, 26'h3FF_FFFF, "R5 jump to 0FFFFFFC");
      drive(0, 0, 0, 1, 16'h0000, 26'h0000005, "R8 jump takes region of PC+4");
      drive(0, 1, 1, 0, 16'h7FFF, 26'h0, "R9 largest forward offset");
      drive(0, 1, 1, 0, 16'h8000, 26'h0, "R9 largest backward offset");
      drive(0, 1, 1, 1, 16'h0100, 26'h0000100, "R6 jump beats taken branch");
      drive(0, 1, 0, 1, 16'h0100, 26'h0000200, "R6 jump with untaken branch");
      drive(0, 1, 1, 0, 16'hFFFF, 26'h0, "R3 offset minus one");
      drive(0, 0, 0, 0, 16'h0000, 26'h0, "R2 step after branch");
      @(negedge clk);
      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2 pending=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired pc=%h expected=finished", pc_q);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule